// File: doc/BRIEF.md
# Column Counter for Correlated Multiple Sampling

This block is the digital half of one column of a single-slope converter. It is used for low-noise readout. A sequencer opens ramp windows, and an external comparator tells the block when the ramp has reached the sampled column level. While a window is open, the block counts clock cycles until the comparator trips. It does not clear between windows, so a run of M windows leaves the sum of M conversions in the counter.

A row is read in a fixed order:
- A clear empties the counter.
- M windows convert the pixel reset level.
- A single inversion pulse flips every counter bit, which leaves minus the reset sum, less one.
- M more windows convert the signal level.

The sequencer marks the final signal window. When that window closes, the block adds one to the counter to undo the offset that the one's complement leaves. It then latches the sum difference and raises a valid flag for one cycle. The logic is the same for every M. M is set only by how many windows the sequencer opens.

Top module: `cms_col_counter`

## Requirements
- R1: After reset, `res_valid` is 0, `res_data` is 0 and the internal counter is 0.
- R2: In an open window (`win_en` high), the counter adds one on each clock where `cmp_trip` is low and has not yet been high in that window. A window where the comparator first trips after N counting clocks adds exactly N.
- R3: Once `cmp_trip` has been high during a window, counting stays halted until `win_en` goes low, even if `cmp_trip` drops back. The next window is armed again.
- R4: The counter is not cleared between windows, so consecutive windows add their counts together.
- R5: A clock with `inv_pulse` high replaces every counter bit with its complement in that one clock. It takes priority over counting, and it is outranked only by `clr`.
- R6: With correction enabled (`CORRECT_EN`=1), the latched result equals (sum of signal counts) minus (sum of reset counts), modulo 2^16, read as a 16-bit two's-complement value.
- R7: `res_data` changes only on the clock that first sees `win_en` low after a window during which `last_win` was high. On that clock `res_valid` is 1, and it is 0 on every other clock.
- R8: `clr` sets the counter to 0 and overrides inversion and counting. When `clr` falls on the closing clock of the last window, the latched result is still taken from the counter value before the clear.
- R9: The same logic gives a correct result for any M from 1 to 8, including a full-scale 12-bit signal accumulated 8 times.
- R10: While `win_en` is low and neither `clr` nor `inv_pulse` is high, the counter holds its value and `cmp_trip` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous counter clear, issued at the start of a row |
| win_en | input | 1 | Ramp window active |
| cmp_trip | input | 1 | Comparator output; high once the ramp has reached the level |
| inv_pulse | input | 1 | One-clock pulse that complements every counter bit |
| last_win | input | 1 | Held high during the final signal window of a row |
| res_valid | output | 1 | One-clock pulse when a new result is latched |
| res_data | output | 16 | Latched difference of the two sample sums, two's complement |

## Verification
The clear for the next row and the closing of the last signal window can fall on the same clock. Clear acts on the counter, and the close reads the counter into the result register. The bench provokes this by raising `clr` on exactly the clock where `win_en` first drops after the final window. It then checks two things:
- The latched result still equals the difference computed before the clear.
- The following conversion, started without any separate clear, produces its own correct difference. That second check shows that the counter really reached zero.

// File: rtl/cms_pkg.sv
// Shared definitions for the column counter. It holds the operation code
// that the window gate hands to the bit slices, and the width rule.
package cms_pkg;

    // Operation applied to the counter on the next clock, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_COUNT  = 2'd1,
        OP_INVERT = 2'd2,
        OP_CLEAR  = 2'd3
    } cnt_op_e;

    // Counter width: the per-ramp resolution, plus room for the sample sum,
    // plus a sign bit.
    function automatic int calc_cnt_w(input int res_w, input int max_samples);
        return res_w + $clog2(max_samples) + 1;
    endfunction

endpackage

// File: rtl/cms_window_gate.sv
// Window gate: turns the sequencer strobes and the comparator bit into one
// counter operation per clock, and detects when the last window closes.
// Assumes: cmp_trip is already synchronous to clk; win_en falls for at
// least one clock between windows; last_win is steady during a window.
module cms_window_gate (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              win_en,
    input  logic              cmp_trip,
    input  logic              inv_pulse,
    input  logic              last_win,
    output cms_pkg::cnt_op_e  op,
    output logic              close_stb
);
    import cms_pkg::*;

    logic halt_q;   // comparator has tripped in the current window
    logic win_q;    // win_en one clock ago
    logic last_q;   // the most recent window was the last one of the row

    // Sticky halt: set by the first trip inside a window, cleared when the window ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (!win_en) begin
            halt_q <= 1'b0;
        end else if (cmp_trip) begin
            halt_q <= 1'b1;
        end
    end

    // Track the window edge and remember whether the window is the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= 1'b0;
            last_q <= 1'b0;
        end else begin
            win_q <= win_en;
            if (win_en) begin
                last_q <= last_win;
            end
        end
    end

    // The close strobe is the first clock after the final window.
    assign close_stb = win_q & ~win_en & last_q;

    // Priority decode: clear over invert over count.
    always_comb begin
        if (clr) begin
            op = OP_CLEAR;
        end else if (inv_pulse) begin
            op = OP_INVERT;
        end else if (win_en && !cmp_trip && !halt_q) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cms_bitinv_counter.sv
// Bit-inverting up counter: a row of identical one-bit slices. Each slice
// can toggle on a ripple carry, complement itself, clear, or hold.
// Assumes: op is stable before the clock edge; wrap is modulo 2**CNT_W.
module cms_bitinv_counter #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cms_pkg::cnt_op_e  op,
    output logic [CNT_W-1:0]  cnt
);
    import cms_pkg::*;

    logic [CNT_W-1:0] carry;   // toggle enable into each slice

    for (genvar b = 0; b < CNT_W; b++) begin : g_slice
        // Carry into slice b: counting is active and all lower bits are one.
        if (b == 0) begin : g_c0
            assign carry[b] = (op == OP_COUNT);
        end else begin : g_cn
            assign carry[b] = carry[b-1] & cnt[b-1];
        end

        // Per-bit state update for the selected operation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[b] <= 1'b0;
            end else begin
                case (op)
                    OP_CLEAR:  cnt[b] <= 1'b0;
                    OP_INVERT: cnt[b] <= ~cnt[b];
                    OP_COUNT:  cnt[b] <= cnt[b] ^ carry[b];
                    default:   cnt[b] <= cnt[b];
                endcase
            end
        end
    end

endmodule

// File: rtl/cms_result_latch.sv
// Result latch: on the close strobe, captures the counter value (plus the
// optional one's-complement correction) and pulses valid for one clock.
// Assumes: close_stb lasts one clock and cnt is the value before that edge.
module cms_result_latch #(
    parameter int   CNT_W      = 16,
    parameter logic CORRECT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close_stb,
    input  logic [CNT_W-1:0]  cnt,
    output logic              res_valid,
    output logic [CNT_W-1:0]  res_data
);
    localparam logic [CNT_W-1:0] CORR = CNT_W'(CORRECT_EN);

    // Capture the corrected difference and raise a one-clock valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= close_stb;
            if (close_stb) begin
                res_data <= cnt + CORR;
            end
        end
    end

endmodule

// File: rtl/cms_col_counter.sv
// Column counter for correlated multiple sampling. It ties the window gate,
// the bit-inverting counter and the result latch together.
// Assumes: the sequencer gives clr, M reset windows, one inv_pulse, then M
// signal windows with last_win high on the final one.
module cms_col_counter #(
    parameter int   RES_W       = 12,
    parameter int   MAX_SAMPLES = 8,
    parameter logic CORRECT_EN  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         win_en,
    input  logic         cmp_trip,
    input  logic         inv_pulse,
    input  logic         last_win,
    output logic         res_valid,
    output logic [15:0]  res_data
);
    localparam int CNT_W = cms_pkg::calc_cnt_w(RES_W, MAX_SAMPLES);

    cms_pkg::cnt_op_e  op;
    logic              close_stb;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  res_full;

    cms_window_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .win_en    (win_en),
        .cmp_trip  (cmp_trip),
        .inv_pulse (inv_pulse),
        .last_win  (last_win),
        .op        (op),
        .close_stb (close_stb)
    );

    cms_bitinv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .cnt   (cnt_q)
    );

    cms_result_latch #(.CNT_W(CNT_W), .CORRECT_EN(CORRECT_EN)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .close_stb (close_stb),
        .cnt       (cnt_q),
        .res_valid (res_valid),
        .res_data  (res_full)
    );

    // Port width is fixed for the default configuration; fit the result to it.
    assign res_data = 16'(res_full);

endmodule

// File: rtl/cms_col_counter_chk.sv
// Checker for the column counter: relates the strobes, the internal
// counter and the result outputs over time. Bound to every instance of the top.
module cms_col_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              win_en,
    input logic              inv_pulse,
    input logic              res_valid,
    input logic [15:0]       res_data,
    input logic [CNT_W-1:0]  cnt_value
);
    // R8: a clear empties the counter on the next clock.
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_value == '0));

    // R5: an inversion pulse complements every bit.
    a_r5_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_pulse && !clr) |=> (cnt_value == ~$past(cnt_value)));

    // R10: outside a window and without strobes, the counter holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_en && !clr && !inv_pulse) |=> $stable(cnt_value));

    // R2: inside a window the counter either holds or steps by exactly one.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && !clr && !inv_pulse) |=>
            (cnt_value == $past(cnt_value) || cnt_value == $past(cnt_value) + 1'b1));

    // R7: valid is a single-clock pulse.
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R7: the result changes only together with valid.
    a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_data == $past(res_data)));

endmodule

bind cms_col_counter cms_col_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .win_en    (win_en),
    .inv_pulse (inv_pulse),
    .res_valid (res_valid),
    .res_data  (res_data),
    .cnt_value (cnt_q)
);

// File: tb/cms_col_counter_bench.sv
// Bench for the column counter: directed corner cases and seeded random conversions.
module cms_col_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        win_en = 1'b0;
    logic        cmp_trip = 1'b0;
    logic        inv_pulse = 1'b0;
    logic        last_win = 1'b0;
    logic        res_valid;
    logic [15:0] res_data;

    int n_chk = 0;
    int n_fail = 0;
    int rv[8];
    int sv[8];
    logic [15:0] prev_res = 16'd0;

    cms_col_counter u_cms_col_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .win_en    (win_en),
        .cmp_trip  (cmp_trip),
        .inv_pulse (inv_pulse),
        .last_win  (last_win),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Idle clocks with a noisy comparator (R10: it must be ignored).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            cmp_trip = 1'($urandom % 2);
            cyc();
        end
        cmp_trip = 1'b0;
    endtask

    // One ramp window; the ramp reaches the level after 'level' clocks.
    task automatic run_window(input int level, input bit last, input bit glitch);
        win_en   = 1'b1;
        last_win = last;
        for (int k = 0; k < level + 3; k++) begin
            cmp_trip = (k >= level);
            if (glitch && k == level + 1) cmp_trip = 1'b0;  // R3 comparator drops back
            cyc();
        end
        win_en   = 1'b0;
        cmp_trip = 1'b0;
        last_win = 1'b0;
    endtask

    // Full row: optional clear, M reset windows, invert, M signal windows, close.
    task automatic conversion(input int m, input bit pre_clr, input bit clr_close,
                              input bit glitch, input string tag);
        int sum_r = 0;
        int sum_s = 0;
        logic [15:0] exp16;
        for (int i = 0; i < m; i++) begin
            sum_r += rv[i];
            sum_s += sv[i];
        end
        exp16 = 16'(sum_s - sum_r);
        if (pre_clr) begin
            clr = 1'b1;
            cyc();
            clr = 1'b0;
        end
        for (int i = 0; i < m; i++) begin
            run_window(rv[i], 1'b0, glitch && i == 0);
            idle(1 + int'($urandom % 2));
            if (i == 0) begin
                // R7: a non-final window must not touch the result
                chk(!res_valid && res_data == prev_res, {"R7 held ", tag},
                    int'(res_data), int'(prev_res));
            end
        end
        inv_pulse = 1'b1;
        cyc();
        inv_pulse = 1'b0;
        idle(1);
        for (int i = 0; i < m; i++) begin
            run_window(sv[i], i == m - 1, glitch && i == 0);
            if (i != m - 1) idle(1);
        end
        if (clr_close) clr = 1'b1;  // R8 clear on the closing clock
        cyc();
        clr = 1'b0;
        chk(res_valid == 1'b1, {"R7 valid ", tag}, int'(res_valid), 1);
        chk(res_data == exp16, {"R2/R4/R5/R6 result ", tag}, int'(res_data), int'(exp16));
        cyc();
        chk(res_valid == 1'b0 && res_data == exp16, {"R7 pulse ", tag},
            int'(res_valid), 0);
        prev_res = exp16;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
        chk(res_data == 16'd0, "R1 data", int'(res_data), 0);

        // R9 plain CDS, M=1
        rv[0] = 5; sv[0] = 40;
        conversion(1, 1'b0, 1'b0, 1'b0, "R9 m1");

        // R6 negative difference with wrap, M=4
        for (int i = 0; i < 4; i++) begin rv[i] = 100 + i; sv[i] = 10; end
        conversion(4, 1'b1, 1'b0, 1'b0, "R6 neg");

        // R3 comparator glitch after trip, M=2
        rv[0] = 7; rv[1] = 3; sv[0] = 20; sv[1] = 9;
        conversion(2, 1'b1, 1'b0, 1'b1, "R3 glitch");

        // R8 clear on closing clock, then a row with no separate clear
        rv[0] = 12; rv[1] = 30; rv[2] = 0; sv[0] = 50; sv[1] = 60; sv[2] = 70;
        conversion(3, 1'b1, 1'b1, 1'b0, "R8 close");
        rv[0] = 4; sv[0] = 9;
        conversion(1, 1'b0, 1'b0, 1'b0, "R8 after");

        // R9 full scale, M=8
        for (int i = 0; i < 8; i++) begin rv[i] = 0; sv[i] = 4095; end
        conversion(8, 1'b1, 1'b0, 1'b0, "R9 full");

        // Random rows, R4 accumulation across 1..8 windows
        for (int n = 0; n < 16; n++) begin
            int m = 1 + int'($urandom % 8);
            for (int i = 0; i < 8; i++) begin
                rv[i] = int'($urandom % 200);
                sv[i] = int'($urandom % 200);
            end
            conversion(m, 1'b1, 1'b0, (n % 4) == 1, "R4 rand");
        end

        summary();
        $finish;
    end

endmodule